// File: doc/BRIEF.md
# Self-Repairing 12x12 Nibble-Array Multiplier

This block multiplies two 12-bit unsigned operands into a 24-bit product. Each operand is cut into three 4-bit groups. Nine 4x4 nibble multipliers, one for each pairing of an A group with a B group, form the partial-product array. The partial products are shifted by the sum of their group weights and added. Operands are taken on every clock edge, and the product appears one edge later.

One extra 4x4 multiplier is held in reserve and can stand in for any of the nine array tiles. A repair setting holds three fields: an enable, an A-group index and a B-group index. It is loaded into registers with a synchronous strobe. While a repair is active, the spare receives the chosen tile's operand nibbles. The spare's result then replaces that tile's output before accumulation, and the chosen tile's power-enable output is driven low.

Detecting faults is left to logic outside this block. For verification, a per-tile override input can force any tile's 8-bit result to a stuck value.

Top module: `rep_mul12`

## Requirements
- R1: With no override active, `prod_o` equals `a_i * b_i`, using the operand values captured at the previous rising clock edge.
- R2: The repair setting changes only on an edge where `cfg_ld_i` is 1. With the strobe low, values on `cfg_en_i`, `cfg_arow_i` and `cfg_bcol_i` have no effect.
- R3: While a repair is active, `pwr_en_o` bit `arow*3 + bcol` is 0 and every other bit is 1. Here `arow` is the A-group index (A nibble `a_i[4*arow+3:4*arow]`) and `bcol` is the B-group index.
- R4: A repair is active only when the enable field is 1 and both indices are 0, 1 or 2. With the enable at 0, or with either index at 3, all `pwr_en_o` bits are 1 and no tile output is replaced.
- R5: When `flt_en_i[k]` is 1 and tile k is not being repaired, that tile contributes `flt_val_i[8k+7:8k]` in place of its true nibble product. The product then differs from `a_i*b_i` whenever the stuck value differs from the true tile product.
- R6: While tile k is being repaired, an override on tile k has no effect, and the product equals `a_i*b_i`.
- R7: Repairing one tile does not hide an override on a different tile.
- R8: After reset, `prod_o` is 0, no repair is active and all `pwr_en_o` bits are 1.
- R9: A setting loaded at edge E is first used by the operation that is captured at edge E+1. The operation captured at edge E still uses the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 12 | Operand A |
| b_i | input | 12 | Operand B |
| cfg_ld_i | input | 1 | Strobe that loads the repair setting |
| cfg_en_i | input | 1 | Repair enable field |
| cfg_arow_i | input | 2 | A-group index of the tile to repair |
| cfg_bcol_i | input | 2 | B-group index of the tile to repair |
| flt_en_i | input | 9 | Per-tile stuck-value override enable |
| flt_val_i | input | 72 | Per-tile stuck values, 8 bits per tile |
| prod_o | output | 24 | Registered product |
| pwr_en_o | output | 9 | Per-tile power enable, low for the repaired tile |

## Verification
Operand patterns include zero, all ones, alternating nibbles and single set bits. Alternating nibbles and single set bits separate errors in the shift weight of each tile from errors in its nibble selection. Each of the nine tiles is overridden in turn, first with no repair and then with a repair aimed at it. This shows that the spare's operand routing and its output splice both match the chosen index. Aiming the repair at a healthy tile while another tile is overridden, and loading a setting on the same edge as an operation, separate a correct splice from one that masks every fault or takes effect one edge early.

// File: rtl/repmul_pkg.sv
`timescale 1ns/1ps
package repmul_pkg;
  parameter int NIB_W = 4;
  parameter int GRP_N = 3;
  parameter int IDX_W = 2;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] arow;
    logic [IDX_W-1:0] bcol;
  } rep_cfg_t;
endpackage

// File: rtl/rm_nib_mul.sv
`timescale 1ns/1ps
module rm_nib_mul #(
  parameter int NIB = 4
) (
  input  logic [NIB-1:0]   a_i,
  input  logic [NIB-1:0]   b_i,
  input  logic             pwr_en_i,
  input  logic             flt_en_i,
  input  logic [2*NIB-1:0] flt_val_i,
  output logic [2*NIB-1:0] p_o
);
  localparam int PW = 2 * NIB;

  // A powered-down tile gives zero; an override replaces the true product.
  always_comb begin
    if (!pwr_en_i)     p_o = '0;
    else if (flt_en_i) p_o = flt_val_i;
    else               p_o = PW'(a_i) * PW'(b_i);
  end
endmodule

// File: rtl/rm_spare_route.sv
`timescale 1ns/1ps
module rm_spare_route #(
  parameter int NIB = 4,
  parameter int G   = 3,
  parameter int IW  = 2
) (
  input  logic [NIB*G-1:0] a_i,
  input  logic [NIB*G-1:0] b_i,
  input  logic             act_i,
  input  logic [IW-1:0]    arow_i,
  input  logic [IW-1:0]    bcol_i,
  output logic [2*NIB-1:0] p_o
);
  logic [NIB-1:0] sa, sb;

  // Nibble selection; the operands stay at zero while the spare is idle.
  always_comb begin
    sa = '0;
    sb = '0;
    for (int g = 0; g < G; g++) begin
      if (act_i && arow_i == IW'(g)) sa = a_i[g*NIB +: NIB];
      if (act_i && bcol_i == IW'(g)) sb = b_i[g*NIB +: NIB];
    end
  end

  rm_nib_mul #(.NIB(NIB)) u_spare (
    .a_i       (sa),
    .b_i       (sb),
    .pwr_en_i  (act_i),
    .flt_en_i  (1'b0),
    .flt_val_i ('0),
    .p_o       (p_o)
  );
endmodule

// File: rtl/rm_tile_sum.sv
`timescale 1ns/1ps
module rm_tile_sum #(
  parameter int NIB = 4,
  parameter int G   = 3
) (
  input  logic [G*G-1:0][2*NIB-1:0] p_i,
  output logic [2*NIB*G-1:0]        sum_o
);
  localparam int NT   = G * G;
  localparam int PR_W = 2 * NIB * G;

  logic [NT-1:0][PR_W-1:0] term;

  for (genvar i = 0; i < G; i++) begin : g_row
    for (genvar j = 0; j < G; j++) begin : g_col
      assign term[i*G+j] = PR_W'(p_i[i*G+j]) << (NIB * (i + j));
    end
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < NT; k++) sum_o = sum_o + term[k];
  end
endmodule

// File: rtl/rep_mul12.sv
`timescale 1ns/1ps
module rep_mul12
  import repmul_pkg::*;
#(
  parameter int NIB = NIB_W,
  parameter int G   = GRP_N,
  parameter int IW  = IDX_W,
  localparam int OP_W = NIB * G,
  localparam int PP_W = 2 * NIB,
  localparam int NT   = G * G,
  localparam int PR_W = 2 * OP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic             cfg_ld_i,
  input  logic             cfg_en_i,
  input  logic [IW-1:0]    cfg_arow_i,
  input  logic [IW-1:0]    cfg_bcol_i,
  input  logic [NT-1:0]    flt_en_i,
  input  logic [NT*PP_W-1:0] flt_val_i,
  output logic [PR_W-1:0]  prod_o,
  output logic [NT-1:0]    pwr_en_o
);
  localparam int KW = $clog2(NT);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rsync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  // Repair setting register.
  rep_cfg_t cfg_q, cfg_d;
  always_comb begin
    cfg_d = cfg_q;
    if (cfg_ld_i) begin
      cfg_d.en   = cfg_en_i;
      cfg_d.arow = cfg_arow_i;
      cfg_d.bcol = cfg_bcol_i;
    end
  end
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cfg_q.en   <= 1'b0;
      cfg_q.arow <= '1;
      cfg_q.bcol <= '1;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  logic          rep_act;
  logic [KW-1:0] rep_idx;
  assign rep_act = cfg_q.en && (int'(cfg_q.arow) < G) && (int'(cfg_q.bcol) < G);
  assign rep_idx = KW'(int'(cfg_q.arow) * G + int'(cfg_q.bcol));

  for (genvar k = 0; k < NT; k++) begin : g_pwr
    assign pwr_en_o[k] = !(rep_act && rep_idx == KW'(k));
  end

  // Tile array.
  logic [NT-1:0][PP_W-1:0] tile_p, eff_p;
  logic [PP_W-1:0]         spare_p;

  for (genvar i = 0; i < G; i++) begin : g_arow
    for (genvar j = 0; j < G; j++) begin : g_bcol
      rm_nib_mul #(.NIB(NIB)) u_tile (
        .a_i       (a_i[i*NIB +: NIB]),
        .b_i       (b_i[j*NIB +: NIB]),
        .pwr_en_i  (pwr_en_o[i*G+j]),
        .flt_en_i  (flt_en_i[i*G+j]),
        .flt_val_i (flt_val_i[(i*G+j)*PP_W +: PP_W]),
        .p_o       (tile_p[i*G+j])
      );
      assign eff_p[i*G+j] = pwr_en_o[i*G+j] ? tile_p[i*G+j] : spare_p;
    end
  end

  rm_spare_route #(.NIB(NIB), .G(G), .IW(IW)) u_spare (
    .a_i    (a_i),
    .b_i    (b_i),
    .act_i  (rep_act),
    .arow_i (cfg_q.arow),
    .bcol_i (cfg_q.bcol),
    .p_o    (spare_p)
  );

  logic [PR_W-1:0] sum_w;
  rm_tile_sum #(.NIB(NIB), .G(G)) u_sum (
    .p_i   (eff_p),
    .sum_o (sum_w)
  );

  // Product register.
  logic [PR_W-1:0] prod_q, prod_d;
  assign prod_d = sum_w;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) prod_q <= '0;
    else         prod_q <= prod_d;
  end
  assign prod_o = prod_q;

  // Assertion arming: one edge after reset release.
  logic arm_q;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) arm_q <= 1'b0;
    else         arm_q <= 1'b1;
  end

  // R1: exact product when no override was present
  p_exact_plain_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    (arm_q && $past(flt_en_i) == '0) |-> prod_o == ($past(a_i) * $past(b_i)));

  // R6: a repaired tile's override is harmless
  p_exact_repaired_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (arm_q && $past(rep_act) && ($past(flt_en_i) & $past(pwr_en_o)) == '0)
      |-> prod_o == ($past(a_i) * $past(b_i)));

  // R2: setting stays put without the strobe
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (arm_q && !$past(cfg_ld_i)) |-> $stable(cfg_q));

  // R3: exactly one tile powered down during repair
  p_pwr_single_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    rep_act |-> ($countones(~pwr_en_o) == 1));

  // R4: no repair leaves every tile powered
  p_all_on_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    !rep_act |-> (&pwr_en_o));
endmodule

// File: tb/rep_mul12_test.sv
`timescale 1ns/1ps
module rep_mul12_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] a, b;
  logic        cfg_ld, cfg_en;
  logic [1:0]  cfg_arow, cfg_bcol;
  logic [8:0]  flt_en;
  logic [71:0] flt_val;
  logic [23:0] prod;
  logic [8:0]  pwr_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rep_mul12 uut (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b),
    .cfg_ld_i(cfg_ld), .cfg_en_i(cfg_en), .cfg_arow_i(cfg_arow), .cfg_bcol_i(cfg_bcol),
    .flt_en_i(flt_en), .flt_val_i(flt_val), .prod_o(prod), .pwr_en_o(pwr_en)
  );

  // Expected product from the requirements: nine weighted tile terms.
  function automatic logic [23:0] model(input logic [11:0] x, input logic [11:0] y,
                                        input logic [8:0] fm, input logic [71:0] fv,
                                        input bit ron, input int ridx);
    longint s = 0;
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 3; j++) begin
        int k = i*3 + j;
        longint t = longint'(x[i*4 +: 4]) * longint'(y[j*4 +: 4]);
        if (!(ron && k == ridx) && fm[k]) t = longint'(fv[k*8 +: 8]);
        s = s + (t << (4*(i+j)));
      end
    end
    return s[23:0];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_cfg(input bit en, input logic [1:0] r, input logic [1:0] c);
    @(negedge clk);
    cfg_ld = 1'b1; cfg_en = en; cfg_arow = r; cfg_bcol = c;
    @(negedge clk);
    cfg_ld = 1'b0;
  endtask

  task automatic op(input logic [11:0] x, input logic [11:0] y, input logic [23:0] exp, input string req);
    @(negedge clk);
    a = x; b = y;
    @(negedge clk);
    chk(prod == exp, req, prod, exp);
  endtask

  task automatic t_reset;
    chk(prod == 24'h0, "R8 prod", prod, 0);
    chk(pwr_en == 9'h1ff, "R8 pwr", pwr_en, 9'h1ff);
  endtask

  task automatic t_plain;
    logic [11:0] pa[6] = '{12'h000, 12'hfff, 12'ha5a, 12'h001, 12'h800, 12'h123};
    logic [11:0] pb[6] = '{12'hfff, 12'hfff, 12'h5a5, 12'h800, 12'h010, 12'hfed};
    for (int n = 0; n < 6; n++) op(pa[n], pb[n], 24'(pa[n]*pb[n]), "R1 plain");
  endtask

  task automatic t_pwr_map;
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 3; c++) begin
        load_cfg(1'b1, 2'(r), 2'(c));
        chk(pwr_en == ~(9'h1 << (r*3+c)), "R3 pwr map", pwr_en, ~(9'h1 << (r*3+c)));
        op(12'h9c7, 12'h3be, 24'(12'h9c7*12'h3be), "R3 healthy repair");
      end
    end
  endtask

  task automatic t_no_repair_codes;
    flt_en = 9'h010; flt_val = 72'h0;
    flt_val[4*8 +: 8] = 8'hff;
    load_cfg(1'b1, 2'd3, 2'd1);
    chk(pwr_en == 9'h1ff, "R4 arow3", pwr_en, 9'h1ff);
    op(12'h444, 12'h444, model(12'h444, 12'h444, flt_en, flt_val, 0, 0), "R4 arow3 no splice");
    load_cfg(1'b1, 2'd1, 2'd3);
    chk(pwr_en == 9'h1ff, "R4 bcol3", pwr_en, 9'h1ff);
    load_cfg(1'b0, 2'd1, 2'd1);
    chk(pwr_en == 9'h1ff, "R4 en0", pwr_en, 9'h1ff);
    op(12'h444, 12'h444, model(12'h444, 12'h444, flt_en, flt_val, 0, 0), "R4 en0 no splice");
    flt_en = 9'h0;
  endtask

  task automatic t_hold;
    load_cfg(1'b1, 2'd2, 2'd0);
    @(negedge clk);
    cfg_en = 1'b1; cfg_arow = 2'd0; cfg_bcol = 2'd1;
    @(negedge clk);
    @(negedge clk);
    chk(pwr_en == ~(9'h1 << 6), "R2 hold", pwr_en, ~(9'h1 << 6));
  endtask

  task automatic t_faults;
    logic [11:0] x = 12'hb7d;
    logic [11:0] y = 12'he69;
    for (int k = 0; k < 9; k++) begin
      flt_en = 9'h1 << k;
      flt_val = 72'h0;
      flt_val[k*8 +: 8] = 8'hff;
      load_cfg(1'b0, 2'd0, 2'd0);
      op(x, y, model(x, y, flt_en, flt_val, 0, 0), "R5 fault visible");
      chk(prod != 24'(x*y), "R5 fault differs", prod, 24'(x*y));
      load_cfg(1'b1, 2'(k/3), 2'(k%3));
      op(x, y, 24'(x*y), "R6 repaired");
    end
    flt_en = 9'h0;
  endtask

  task automatic t_wrong_target;
    flt_en = 9'h002; flt_val = 72'h0;
    load_cfg(1'b1, 2'd2, 2'd2);
    op(12'hfff, 12'h0f0, model(12'hfff, 12'h0f0, flt_en, flt_val, 1, 8), "R7 other fault");
    chk(prod != 24'(12'hfff*12'h0f0), "R7 still wrong", prod, 24'(12'hfff*12'h0f0));
    flt_en = 9'h0;
  endtask

  task automatic t_timing;
    flt_en = 9'h100; flt_val = 72'h0;
    load_cfg(1'b0, 2'd0, 2'd0);
    @(negedge clk);
    a = 12'hf0f; b = 12'hf0f;
    cfg_ld = 1'b1; cfg_en = 1'b1; cfg_arow = 2'd2; cfg_bcol = 2'd2;
    @(negedge clk);
    cfg_ld = 1'b0;
    chk(prod == model(12'hf0f, 12'hf0f, flt_en, flt_val, 0, 0), "R9 old setting", prod,
        model(12'hf0f, 12'hf0f, flt_en, flt_val, 0, 0));
    @(negedge clk);
    chk(prod == 24'(12'hf0f*12'hf0f), "R9 new setting", prod, 24'(12'hf0f*12'hf0f));
    flt_en = 9'h0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; a = '0; b = '0;
    cfg_ld = 1'b0; cfg_en = 1'b0; cfg_arow = '0; cfg_bcol = '0;
    flt_en = '0; flt_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_plain();
    t_pwr_map();
    t_no_repair_codes();
    t_hold();
    t_faults();
    t_wrong_target();
    t_timing();
    done = 1'b1;
    summary();
  end
endmodule